// File: doc/BRIEF.md
# Gapped Horizontal Slot Counter

This block produces the horizontal slot count of a tile-based video controller. It advances once for each access slot granted on its slot-enable input, across an 8-bit value range. It supports two horizontal modes, narrow and wide. Each mode skips its own band of values partway through the line, so the narrow mode has 171 slots per line and the wide mode has 210. A line here starts at the horizontal-interrupt count, and the count is the horizontal half of the value a host reads from the beam position counter.

A surrounding timing unit drives `slot_en` at the slot rate for the selected mode. That is about one slot per 2.85 CPU clocks in narrow mode and one per 2.32 in wide mode, with 488 CPU clocks per line. The unit uses `hint_pulse` to raise its horizontal interrupt and `eol` to prepare for the line boundary. A mode request on `wide_sel` is held back until the line boundary, so no line mixes the gap rules of the two modes.

Top module: `hslot_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `hcount` loads the interrupt count of the mode on `wide_sel` (0x84 narrow when `wide_sel`=0, 0xA4 wide when `wide_sel`=1), and `slot_stb`, `hint_pulse` and `eol` are 0.
- R2: Each clock edge with `slot_en`=1 moves `hcount` to its next value, and `slot_stb` is 1 in the following cycle. An edge with `slot_en`=0 leaves `hcount` unchanged and gives `slot_stb`=0.
- R3: The count wraps from 0xFF to 0x00.
- R4: In narrow mode the step after 0x93 goes to 0xE9. Values 0x94 to 0xE8 never appear.
- R5: In wide mode the step after 0xB6 goes to 0xE5. Values 0xB7 to 0xE4 never appear.
- R6: `hint_pulse` is 1 for exactly the one slot in which `hcount` has just become the interrupt count of the active mode (0x84 narrow, 0xA4 wide).
- R7: Counting slot steps from one `hint_pulse` to the next gives 171 in narrow mode and 210 in wide mode. This holds both with `slot_en` every cycle and with `slot_en` from a fractional accumulator of 488 CPU clocks per line.
- R8: `eol` is 1 for exactly the one slot in which `hcount` has just become the interrupt count minus one (0x83 narrow, 0xA3 wide), which is the last slot of a line.
- R9: `wide_sel` is sampled only on the step out of the last slot of a line. That step loads the interrupt count of the requested mode, and the new mode's gap rule applies from then on. A change of `wide_sel` in mid-line has no effect on the rest of that line.
- R10: `hint_pulse` and `eol` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_en | input | 1 | Advance the count by one slot at this edge |
| wide_sel | input | 1 | Requested mode: 0 narrow, 1 wide |
| hcount | output | 8 | Current horizontal slot count |
| slot_stb | output | 1 | A slot step took place at the last edge |
| hint_pulse | output | 1 | Count has just reached the interrupt point |
| eol | output | 1 | Count has just reached the last slot of the line |

## Verification
The interesting coincidence is a mode request that arrives on the very edge that steps out of the last slot of a line. In that cycle, the line-boundary reload and the mode latch both act on the same `wide_sel` sample. The bench raises `eol`, then flips `wide_sel` just before the next enabled edge. It expects the count to land on the other mode's interrupt count with `hint_pulse` set, and the following line to show that mode's gap and slot total. A second case flips `wide_sel` in mid-line. There, the remaining steps must still follow the old gap and only the boundary step may switch.

// File: rtl/hslot_pkg.sv
// Shared width, mode encoding and per-mode configuration record
// for the gapped horizontal slot counter.
package hslot_pkg;
    localparam int CNT_W     = 8;
    localparam int NUM_MODES = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        HM_NARROW = 1'b0,
        HM_WIDE   = 1'b1
    } hmode_e;

    // hint: interrupt count; gap_first: first skipped value; gap_resume: value after the gap
    typedef struct packed {
        cnt_t hint;
        cnt_t gap_first;
        cnt_t gap_resume;
    } mode_cfg_t;
endpackage

// File: rtl/hslot_cfg_table.sv
// Per-mode configuration lookup.
// Builds one configuration record per mode from the parameters and selects
// two of them: one for the active mode and one for the requested mode.
// Assumes: gap_first > hint for each mode, so the last slot (hint-1) lies
// outside the gap.
module hslot_cfg_table
    import hslot_pkg::*;
#(
    parameter cnt_t NARROW_HINT   = 8'h84,
    parameter cnt_t NARROW_GAP    = 8'h94,
    parameter cnt_t NARROW_RESUME = 8'hE9,
    parameter cnt_t WIDE_HINT     = 8'hA4,
    parameter cnt_t WIDE_GAP      = 8'hB7,
    parameter cnt_t WIDE_RESUME   = 8'hE5
) (
    input  hmode_e    cur_mode,
    input  hmode_e    req_mode,
    output mode_cfg_t cur_cfg,
    output mode_cfg_t req_cfg
);
    mode_cfg_t table_q [NUM_MODES];

    // one constant record per mode, picked by the mode's encoding
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        if (m == int'(HM_WIDE)) begin : g_wide
            assign table_q[m] = '{hint: WIDE_HINT, gap_first: WIDE_GAP,
                                   gap_resume: WIDE_RESUME};
        end else begin : g_narrow
            assign table_q[m] = '{hint: NARROW_HINT, gap_first: NARROW_GAP,
                                   gap_resume: NARROW_RESUME};
        end
    end

    // select the active and the requested configuration
    always_comb begin
        cur_cfg = table_q[cur_mode];
        req_cfg = table_q[req_mode];
    end
endmodule

// File: rtl/hslot_step.sv
// Next-count computation.
// Works out the value that follows the current count: the reload at the line
// boundary, the jump over the gap, or a plain increment with natural wrap.
// It also flags whether the current slot is the last one of the line and
// whether the next value will be.
// Assumes: the count never sits inside the gap of the active mode.
module hslot_step
    import hslot_pkg::*;
(
    input  cnt_t      count,
    input  mode_cfg_t cur_cfg,
    input  mode_cfg_t req_cfg,
    output cnt_t      next_count,
    output logic      at_last,
    output logic      next_is_last
);
    cnt_t inc;
    cnt_t last_val;

    // choose the successor value and the line-boundary flags
    always_comb begin
        last_val     = cur_cfg.hint - cnt_t'(1);
        inc          = count + cnt_t'(1);
        at_last      = (count == last_val);
        if (at_last)
            next_count = req_cfg.hint;
        else if (inc == cur_cfg.gap_first)
            next_count = cur_cfg.gap_resume;
        else
            next_count = inc;
        next_is_last = !at_last && (next_count == last_val);
    end
endmodule

// File: rtl/hslot_counter.sv
// Gapped horizontal slot counter (top).
// Steps the slot count on each slot_en edge and skips the gap of the active
// mode. Mode requests are latched only at the line boundary, and all
// outputs are registered.
// Assumes: slot_en is synchronous to clk; the reset is synchronous, active low.
module hslot_counter
    import hslot_pkg::*;
#(
    parameter cnt_t NARROW_HINT   = 8'h84,
    parameter cnt_t NARROW_GAP    = 8'h94,
    parameter cnt_t NARROW_RESUME = 8'hE9,
    parameter cnt_t WIDE_HINT     = 8'hA4,
    parameter cnt_t WIDE_GAP      = 8'hB7,
    parameter cnt_t WIDE_RESUME   = 8'hE5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_en,
    input  logic             wide_sel,
    output logic [CNT_W-1:0] hcount,
    output logic             slot_stb,
    output logic             hint_pulse,
    output logic             eol
);
    hmode_e    mode_q;
    hmode_e    req_mode;
    mode_cfg_t cur_cfg;
    mode_cfg_t req_cfg;
    cnt_t      count_q;
    cnt_t      next_count;
    logic      at_last;
    logic      next_is_last;

    assign req_mode = hmode_e'(wide_sel);

    hslot_cfg_table #(
        .NARROW_HINT(NARROW_HINT), .NARROW_GAP(NARROW_GAP), .NARROW_RESUME(NARROW_RESUME),
        .WIDE_HINT(WIDE_HINT),     .WIDE_GAP(WIDE_GAP),     .WIDE_RESUME(WIDE_RESUME)
    ) u_cfg (
        .cur_mode (mode_q),
        .req_mode (req_mode),
        .cur_cfg  (cur_cfg),
        .req_cfg  (req_cfg)
    );

    hslot_step u_step (
        .count        (count_q),
        .cur_cfg      (cur_cfg),
        .req_cfg      (req_cfg),
        .next_count   (next_count),
        .at_last      (at_last),
        .next_is_last (next_is_last)
    );

    // count and mode registers: reload on reset, advance on slot_en
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= req_cfg.hint;
            mode_q  <= req_mode;
        end else if (slot_en) begin
            count_q <= next_count;
            if (at_last)
                mode_q <= req_mode;
        end
    end

    // one-slot flags that accompany each count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_stb   <= 1'b0;
            hint_pulse <= 1'b0;
            eol        <= 1'b0;
        end else begin
            slot_stb   <= slot_en;
            hint_pulse <= slot_en && at_last;
            eol        <= slot_en && next_is_last;
        end
    end

    assign hcount = count_q;
endmodule

// File: rtl/hslot_counter_chk.sv
// Property checker for hslot_counter, attached with bind.
// Watches the ports and the latched mode for the gap, interrupt, boundary
// and mode-switch rules.
module hslot_counter_chk
    import hslot_pkg::*;
#(
    parameter cnt_t NARROW_HINT   = 8'h84,
    parameter cnt_t NARROW_GAP    = 8'h94,
    parameter cnt_t NARROW_RESUME = 8'hE9,
    parameter cnt_t WIDE_HINT     = 8'hA4,
    parameter cnt_t WIDE_GAP      = 8'hB7,
    parameter cnt_t WIDE_RESUME   = 8'hE5
) (
    input logic   clk,
    input logic   rst_n,
    input logic   slot_en,
    input cnt_t   hcount,
    input logic   slot_stb,
    input logic   hint_pulse,
    input logic   eol,
    input hmode_e mode_q
);
    cnt_t act_hint;
    assign act_hint = (mode_q == HM_WIDE) ? WIDE_HINT : NARROW_HINT;

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> (hcount == $past(hcount)) && !slot_stb); // R2
    AST_STEP_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en |=> slot_stb); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && $past(hcount) == 8'hFF && !hint_pulse) |-> hcount == 8'h00); // R3
    AST_NARROW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == HM_NARROW) |-> !(hcount >= NARROW_GAP && hcount < NARROW_RESUME)); // R4
    AST_WIDE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == HM_WIDE) |-> !(hcount >= WIDE_GAP && hcount < WIDE_RESUME)); // R5
    AST_HINT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        hint_pulse |-> slot_stb && hcount == act_hint); // R6
    AST_EOL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        eol |-> slot_stb && hcount == act_hint - cnt_t'(1)); // R8
    AST_MODE_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> hint_pulse); // R9
    AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hint_pulse, eol})); // R10
endmodule

bind hslot_counter hslot_counter_chk #(
    .NARROW_HINT(NARROW_HINT), .NARROW_GAP(NARROW_GAP), .NARROW_RESUME(NARROW_RESUME),
    .WIDE_HINT(WIDE_HINT),     .WIDE_GAP(WIDE_GAP),     .WIDE_RESUME(WIDE_RESUME)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_en    (slot_en),
    .hcount     (hcount),
    .slot_stb   (slot_stb),
    .hint_pulse (hint_pulse),
    .eol        (eol),
    .mode_q     (mode_q)
);

// File: tb/sim_hslot_counter.sv
// Directed bench for hslot_counter. Each scenario is a task that checks its
// own results against a reference model written from the requirements.
module sim_hslot_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_en = 1'b0;
    logic       wide_sel = 1'b0;
    logic [7:0] hcount;
    logic       slot_stb;
    logic       hint_pulse;
    logic       eol;

    int n_checks = 0;
    int n_errors = 0;

    // reference model state
    logic [7:0] m_cnt;
    logic       m_wide;

    always #4 clk = ~clk;

    hslot_counter u0 (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .wide_sel(wide_sel),
        .hcount(hcount), .slot_stb(slot_stb), .hint_pulse(hint_pulse), .eol(eol)
    );

    function automatic logic [7:0] hint_of(input logic w);
        return w ? 8'hA4 : 8'h84;
    endfunction
    function automatic logic [7:0] gap_of(input logic w);
        return w ? 8'hB7 : 8'h94;
    endfunction
    function automatic logic [7:0] resume_of(input logic w);
        return w ? 8'hE5 : 8'hE9;
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one clock with the given enable; model update and full output compare
    task automatic step(input logic en);
        logic       exp_hint;
        logic       exp_eol;
        logic [7:0] prev;
        logic [7:0] n;
        string      tag;
        exp_hint = 1'b0;
        exp_eol  = 1'b0;
        tag      = "R2";
        slot_en  = en;
        prev     = m_cnt;
        if (en) begin
            if (m_cnt == hint_of(m_wide) - 8'd1) begin
                m_wide   = wide_sel;
                m_cnt    = hint_of(m_wide);
                exp_hint = 1'b1;
                tag      = "R9";
            end else begin
                n = m_cnt + 8'd1;
                if (n == gap_of(m_wide)) begin
                    n   = resume_of(m_wide);
                    tag = m_wide ? "R5" : "R4";
                end
                if (prev == 8'hFF) tag = "R3";
                m_cnt   = n;
                exp_eol = (m_cnt == hint_of(m_wide) - 8'd1);
            end
        end
        @(posedge clk);
        #1;
        slot_en = 1'b0;
        chk(hcount, m_cnt, tag);
        chk(slot_stb, en, "R2");
        chk(hint_pulse, exp_hint, "R6");
        chk(eol, exp_eol, "R8");
        chk(hint_pulse && eol, 0, "R10");
    endtask

    // R1: synchronous reset into the chosen mode
    task automatic t_reset(input logic w);
        rst_n    = 1'b0;
        slot_en  = 1'b0;
        wide_sel = w;
        repeat (2) @(posedge clk);
        #1;
        chk(hcount, hint_of(w), "R1");
        chk(slot_stb, 0, "R1");
        chk(hint_pulse, 0, "R1");
        chk(eol, 0, "R1");
        rst_n  = 1'b1;
        m_cnt  = hint_of(w);
        m_wide = w;
    endtask

    // R2: idle edges leave the count alone
    task automatic t_hold();
        for (int i = 0; i < 5; i++) step(1'b0);
    endtask

    // R7: step every cycle until the next interrupt point, count the slots
    task automatic t_full_line(input int exp_slots);
        int steps = 0;
        for (int i = 0; i < 400; i++) begin
            step(1'b1);
            steps++;
            if (hint_pulse) break;
        end
        chk(steps, exp_slots, "R7");
    endtask

    // R7: slot_en from a fractional accumulator, 488 CPU clocks per line
    task automatic t_accum_line(input int slots);
        int acc = 0;
        int strobes = 0;
        for (int i = 0; i < 2000; i++) begin
            logic en;
            acc = acc + slots;
            en  = (acc >= 488);
            if (en) acc = acc - 488;
            step(en);
            if (slot_stb) strobes++;
            if (hint_pulse) break;
        end
        chk(strobes, slots, "R7");
    endtask

    // R9: a mid-line request must wait for the boundary
    task automatic t_switch_midline();
        t_reset(1'b0);
        for (int i = 0; i < 20; i++) step(1'b1);
        wide_sel = 1'b1;
        t_full_line(171 - 20);
        chk(hcount, 8'hA4, "R9");
        t_full_line(210);
    endtask

    // R9 with R8: request flips on the very edge that leaves the last slot
    task automatic t_switch_at_boundary();
        for (int i = 0; i < 400; i++) begin
            step(1'b1);
            if (eol) break;
        end
        chk(hcount, 8'hA3, "R8");
        wide_sel = 1'b0;
        step(1'b1);
        chk(hcount, 8'h84, "R9");
        chk(hint_pulse, 1, "R9");
        t_full_line(171);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        t_reset(1'b0);
        t_hold();
        t_full_line(171);
        t_full_line(171);
        t_accum_line(171);
        t_reset(1'b1);
        t_hold();
        t_full_line(210);
        t_accum_line(210);
        t_switch_midline();
        t_switch_at_boundary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule